// File: doc/BRIEF.md
# Eight-Channel Decimated Capture Buffer

This block records eight 16-bit signals at the same instants into eight 1024-word memories, one per channel. Recording starts with a two-step trigger: first an arm bit, then a go bit. From then on one word per channel is written every `interval` data-clock cycles, until each memory holds 1024 words. `busy` stays high while this runs. `done` marks the end with a one-cycle pulse.

The stored words are read later through a second port that runs on its own host clock. A pulse on `hgo` starts the read sequencer. Each cycle with `hread` high takes one word. Channel 0 is read first, then channel 1 and so on, and each channel is read from word 0 to word 1023. The strobes may be spaced out with idle cycles between them, and the sequencer keeps its place across those gaps. The recording busy state is carried into the host clock domain through a two-flop synchronizer, so that a readout cannot start while a capture is still running.

Top module: `wave_capture`

## Requirements
- R1: After reset, `busy`, `done`, `hbusy`, `hdone` and `hsample` are all low.
- R2: `trig[1]` arms the recorder and `trig[0]` starts it. A start is accepted only when the recorder is already armed. A `trig[0]` without a previous arm starts no recording.
- R3: Word k of every channel holds the value `din` carried on the k-th write edge. The first write edge is the one after the start is accepted, and each later write edge comes `interval` cycles after the one before. `interval` is latched when the start is accepted, and a value of 0 behaves as 1.
- R4: `busy` rises after the edge that accepts the start and stays high for exactly 1 + 1023*interval cycles. `done` is high for exactly one cycle, and that is the cycle in which `busy` has fallen.
- R5: An `hgo` pulse raises `hbusy` on the next host cycle and starts reading at address 0. The pulse is ignored if a readout is already running, or if the recording busy state, as seen through the synchronizer, is high.
- R6: Each host cycle in which `hread` and `hbusy` are both high reads one word and advances the read address. That word appears on `hdout` in the next host cycle, together with a one-cycle `hsample` pulse. In cycles without a strobe the address and `hdout` stay as they are.
- R7: The read address is 13 bits wide. Bits 12:10 select the channel and bits 9:0 select the word, and the address counts up from 0. Channel c is `din[16c+15:16c]`.
- R8: `hdone` pulses for one host cycle, in the same cycle that the 8192nd word is on `hdout`. `hbusy` falls in that same cycle and at no other time.
- R9: An `hread` strobe while `hbusy` is low is ignored: `hsample` stays low and `hdout` keeps its value.
- R10: A new capture can be armed after `done`. It overwrites all eight memories with new samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| trig | input | 2 | Bit 1 arms the recorder, bit 0 starts it |
| interval | input | 13 | Data cycles between stored samples (0 acts as 1) |
| din | input | 128 | Eight 16-bit channels; channel 0 in bits 15:0 |
| busy | output | 1 | Recording in progress |
| done | output | 1 | One-cycle pulse at the end of a recording |
| hclk | input | 1 | Host-side clock |
| hgo | input | 1 | Readout start pulse |
| hread | input | 1 | Read strobe; one word for each high cycle |
| hbusy | output | 1 | Readout in progress |
| hdone | output | 1 | One-cycle pulse with the last word |
| hdout | output | 16 | Read data, valid the cycle after a strobe |
| hsample | output | 1 | Pulse marking a fresh word on `hdout` |

## Verification
The bench varies the decimation step and compares every one of the 8192 read words against a value built from the cycle in which it was written. A sequencer that writes one word early or late, or that gets the channel order wrong, therefore fails on the very first word. The read strobes have random gaps between them. A sequencer that advances during a gap would skip words, and an output register that is not held would change `hdout` during a gap. The bench also gives a start bit without arming, an `hgo` during recording, strobes after the readout has finished, and an interval of zero. Each of these shows at once whether a capture or readout starts when it should not, whether a spurious `hsample` appears, or whether the recording length is wrong.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [1:0] {WR_IDLE, WR_ARMED, WR_REC} wr_state_e;
endpackage

// File: rtl/wc_rst_sync.sv
module wc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] ff_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ff_q <= 2'b00;
    else         ff_q <= {ff_q[0], 1'b1};
  end
  assign srst_n = ff_q[1];
endmodule

// File: rtl/wc_sync2.sv
module wc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= 2'b00;
    else        s_q <= {s_q[0], d};
  end
  assign q = s_q[1];
endmodule

// File: rtl/wc_wr_seq.sv
module wc_wr_seq #(
  parameter int AW  = 10,
  parameter int IVW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          go,
  input  logic [IVW-1:0] interval,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          busy,
  output logic          done
);
  import wc_pkg::*;
  localparam logic [AW-1:0] LAST = '1;

  wr_state_e     state_q, state_d;
  logic [IVW-1:0] div_q, div_d, ivl_q, ivl_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           done_q, done_d;

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    ivl_d   = ivl_q;
    addr_d  = addr_q;
    done_d  = 1'b0;
    we      = 1'b0;
    unique case (state_q)
      WR_IDLE:  if (arm) state_d = WR_ARMED;
      WR_ARMED: if (go) begin
        state_d = WR_REC;
        div_d   = '0;
        addr_d  = '0;
        ivl_d   = (interval == '0) ? '0 : interval - 1'b1;
      end
      WR_REC: begin
        if (div_q == '0) begin
          we    = 1'b1;
          div_d = ivl_q;
          if (addr_q == LAST) begin
            state_d = WR_IDLE;
            done_d  = 1'b1;
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end else begin
          div_d = div_q - 1'b1;
        end
      end
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      div_q   <= '0;
      ivl_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      ivl_q   <= ivl_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  assign waddr = addr_q;
  assign busy  = (state_q == WR_REC);
  assign done  = done_q;
endmodule

// File: rtl/wc_chan_ram.sv
module wc_chan_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/wc_rd_seq.sv
module wc_rd_seq #(
  parameter int AW  = 10,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rec_busy,
  input  logic           rd,
  output logic           busy,
  output logic           done,
  output logic           sample,
  output logic           re,
  output logic [AW-1:0]  raddr,
  output logic [CHW-1:0] chsel
);
  localparam int RAW = AW + CHW;
  localparam logic [RAW-1:0] LAST = '1;

  logic           busy_q, busy_d, done_q, done_d, smp_q, smp_d;
  logic [RAW-1:0] addr_q, addr_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic           take;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    ch_d   = ch_q;
    done_d = 1'b0;
    take   = rd && busy_q;
    smp_d  = take;
    if (start && !busy_q && !rec_busy) begin
      busy_d = 1'b1;
      addr_d = '0;
    end
    if (take) begin
      ch_d   = addr_q[RAW-1:AW];
      addr_d = addr_q + 1'b1;
      if (addr_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      smp_q  <= 1'b0;
      addr_q <= '0;
      ch_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      smp_q  <= smp_d;
      addr_q <= addr_d;
      ch_q   <= ch_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign sample = smp_q;
  assign re     = take;
  assign raddr  = addr_q[AW-1:0];
  assign chsel  = ch_q;
endmodule

// File: rtl/wave_capture.sv
module wave_capture #(
  parameter int DW  = 16,
  parameter int NCH = 8,
  parameter int AW  = 10,
  parameter int IVW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trig,
  input  logic [IVW-1:0]    interval,
  input  logic [NCH*DW-1:0] din,
  output logic              busy,
  output logic              done,
  input  logic              hclk,
  input  logic              hgo,
  input  logic              hread,
  output logic              hbusy,
  output logic              hdone,
  output logic [DW-1:0]     hdout,
  output logic              hsample
);
  localparam int CHW = $clog2(NCH);

  logic          d_rst_n, h_rst_n;
  logic          we, re, rec_busy_h;
  logic [AW-1:0] waddr, raddr;
  logic [CHW-1:0] chsel;
  logic [DW-1:0] rdq [NCH];

  wc_rst_sync u_rs_d (.clk(clk),  .arst_n(rst_n), .srst_n(d_rst_n));
  wc_rst_sync u_rs_h (.clk(hclk), .arst_n(rst_n), .srst_n(h_rst_n));

  wc_wr_seq #(.AW(AW), .IVW(IVW)) u_wr (
    .clk(clk), .rst_n(d_rst_n), .arm(trig[1]), .go(trig[0]),
    .interval(interval), .we(we), .waddr(waddr), .busy(busy), .done(done)
  );

  wc_sync2 u_busy_sync (.clk(hclk), .rst_n(h_rst_n), .d(busy), .q(rec_busy_h));

  wc_rd_seq #(.AW(AW), .CHW(CHW)) u_rd (
    .clk(hclk), .rst_n(h_rst_n), .start(hgo), .rec_busy(rec_busy_h),
    .rd(hread), .busy(hbusy), .done(hdone), .sample(hsample),
    .re(re), .raddr(raddr), .chsel(chsel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wc_chan_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk(clk), .we(we), .waddr(waddr), .wdata(din[c*DW +: DW]),
      .rclk(hclk), .re(re), .raddr(raddr), .rdata(rdq[c])
    );
  end

  assign hdout = rdq[chsel];
endmodule

// File: rtl/wave_capture_chk.sv
module wave_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  trig,
  input logic        busy,
  input logic        done,
  input logic        hclk,
  input logic        hread,
  input logic        hbusy,
  input logic        hdone,
  input logic [15:0] hdout,
  input logic        hsample
);
  assert_go_after_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig[0]));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_at_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_needs_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));
  assert_strobe_gives_sample_R6: assert property (@(posedge hclk) disable iff (!rst_n)
    (hread && hbusy) |=> hsample);
  assert_sample_has_strobe_R9: assert property (@(posedge hclk) disable iff (!rst_n)
    hsample |-> $past(hread && hbusy));
  assert_hold_in_gap_R6: assert property (@(posedge hclk) disable iff (!rst_n)
    !(hread && hbusy) |=> $stable(hdout));
  assert_hdone_single_R8: assert property (@(posedge hclk) disable iff (!rst_n)
    hdone |=> !hdone);
  assert_hdone_with_word_R8: assert property (@(posedge hclk) disable iff (!rst_n)
    hdone |-> (hsample && !hbusy));
  assert_hbusy_fall_R8: assert property (@(posedge hclk) disable iff (!rst_n)
    $fell(hbusy) |-> hdone);
endmodule

bind wave_capture wave_capture_chk chk_i (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .done(done),
  .hclk(hclk), .hread(hread), .hbusy(hbusy), .hdone(hdone),
  .hdout(hdout), .hsample(hsample)
);

// File: tb/wave_capture_tb.sv
`timescale 1ns/100ps
module wave_capture_tb_top;
  logic         clk, rst_n, hclk, hgo, hread;
  logic [1:0]   trig;
  logic [12:0]  interval;
  logic [127:0] din;
  logic         busy, done, hbusy, hdone, hsample;
  logic [15:0]  hdout;
  int errors = 0, checks = 0, dcyc = 0;
  int g_edge, iv_eff;

  wave_capture dut_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .interval(interval), .din(din),
    .busy(busy), .done(done), .hclk(hclk), .hgo(hgo), .hread(hread),
    .hbusy(hbusy), .hdone(hdone), .hdout(hdout), .hsample(hsample)
  );

  function automatic logic [15:0] word_of(int c, int n);
    return {3'(c), 13'(n)};
  endfunction

  function automatic logic [127:0] pat(int n);
    logic [127:0] v;
    for (int c = 0; c < 8; c++) v[c*16 +: 16] = word_of(c, n);
    return v;
  endfunction

  function automatic logic [15:0] expect_word(int idx);
    return word_of(idx / 1024, g_edge + 1 + (idx % 1024) * iv_eff);
  endfunction

  initial begin
    clk = 0; din = pat(0);
    forever begin
      #1.5; clk = 1; #2.5; clk = 0; #1; dcyc++; din = pat(dcyc);
    end
  end
  initial begin hclk = 0; forever #3.5 hclk = ~hclk; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic capture(input int iv);
    int cnt = 0;
    interval = 13'(iv);
    iv_eff = (iv == 0) ? 1 : iv;
    @(negedge clk); trig = 2'b10;
    @(negedge clk); trig = 2'b01; g_edge = dcyc + 1;
    @(negedge clk); trig = 2'b00;
    chk(busy === 1'b1, "R2 start after arm", busy, 1);
    while (busy === 1'b1 && cnt < 20000) begin
      if (done) chk(0, "R4 done during busy", done, 0);
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 1 + 1023 * iv_eff, "R4 busy length", cnt, 1 + 1023 * iv_eff);
    chk(done === 1'b1, "R4 done at busy fall", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R4 done one cycle", done, 0);
  endtask

  task automatic readout(input bit gaps);
    logic [15:0] prev;
    repeat (4) @(negedge hclk);
    hgo = 1; @(negedge hclk); hgo = 0;
    chk(hbusy === 1'b1, "R5 hgo starts", hbusy, 1);
    prev = hdout;
    for (int i = 0; i < 8192; i++) begin
      int gap = gaps ? int'($urandom_range(2, 0)) : 0;
      for (int k = 0; k < gap; k++) begin
        hread = 0; @(negedge hclk);
        if (i > 0) chk(hsample === 1'b0 && hdout === prev, "R6 gap holds", {15'd0, hsample, hdout}, {16'd0, prev});
      end
      hread = 1; @(negedge hclk);
      chk(hdout === expect_word(i), "R3 R7 word", hdout, expect_word(i));
      if (hsample !== 1'b1) chk(0, "R6 sample pulse", hsample, 1);
      if (hdone !== (i == 8191)) chk(0, "R8 hdone timing", hdone, (i == 8191));
      if (hbusy !== (i != 8191)) chk(0, "R8 hbusy", hbusy, (i != 8191));
      prev = hdout;
    end
    hread = 0; @(negedge hclk);
    chk(hdone === 1'b0, "R8 hdone one cycle", hdone, 0);
    for (int k = 0; k < 3; k++) begin
      hread = 1; @(negedge hclk);
      chk(hsample === 1'b0 && hdout === prev, "R9 idle strobe ignored", {15'd0, hsample, hdout}, {16'd0, prev});
    end
    hread = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; trig = 0; interval = 13'd1; hgo = 0; hread = 0;
    #23 rst_n = 1;
    repeat (5) @(negedge clk);
    chk({busy, done, hbusy, hdone, hsample} === 5'b0, "R1 reset state",
        {busy, done, hbusy, hdone, hsample}, 0);
    trig = 2'b01; repeat (5) @(negedge clk); trig = 2'b00;
    chk(busy === 1'b0, "R2 go without arm", busy, 0);
    capture(1);
    readout(1);
    fork
      capture(int'($urandom_range(4, 2)));
      begin
        #1500;
        @(negedge hclk); hgo = 1; @(negedge hclk); hgo = 0;
        repeat (3) @(negedge hclk);
        chk(hbusy === 1'b0, "R5 hgo ignored while recording", hbusy, 0);
      end
    join
    readout(1);
    capture(0);
    readout(0);
    chk(1, "R10 recapture overwrote memories", 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule